// File: doc/BRIEF.md
# Filter Key Hash and Probe Step Unit

This unit turns a 32-bit flow key into the two numbers that a hashed lookup table needs before it starts probing. The first is a 16-bit hash that picks the first slot. The second is a 16-bit step that is added on each collision. The hash is a linear-feedback mixing of the key over 32 rounds with feedback taps x^16 + x^3 + 1. It runs as two 16-round stages, each written as shift-and-XOR folds. The step is twice the key minus one, truncated to 16 bits, so it is always odd and can reach every slot of a power-of-two table.

Keys enter through a valid/ready pair and results leave through a second valid/ready pair. Both results sit in output registers. The parameter `SERIAL_MODE` selects one of two builds:
- **Single-cycle build** (`SERIAL_MODE=0`): computes the hash in one combinational pass.
- **Serial build** (`SERIAL_MODE=1`): folds in `SER_BITS` key bits per cycle and accumulates a precomputed column term for each set key bit. It produces exactly the same hash.

Table indexing and entry comparison are left to the logic that uses the results.

Top module: `keyhash_unit`

## Requirements
- R1: `out_hash` is computed as follows, with every value held to 16 bits:
  1. Start with t = 0x1FFF XOR key[31:16].
  2. Fold t with t ^= (t>>3) ^ (t>>6), then t ^= (t>>9).
  3. Set t = t ^ (t<<13) ^ key[15:0].
  4. Fold t again in the same way as step 2.
  5. The result is t.
- R2: `out_incr` equals (key*2 - 1) modulo 2^16, so bit 0 of `out_incr` is always 1 whenever `out_valid` is high.
- R3: In the single-cycle build, a key accepted on a clock edge (`in_valid` and `in_ready` both high) has its results on the outputs with `out_valid` high right after that same edge, that is, one cycle after the key was presented.
- R4: In the serial build, `out_valid` stays low for the first 31 cycles after a key is accepted. It rises exactly 32 cycles after the key was presented. The hash is bit-identical to R1.
- R5: In the single-cycle build, `in_ready` is high when no result is held or when the held result is being taken. In the serial build, `in_ready` is high only when the unit is neither computing nor holding a result.
- R6: While `out_valid` is high and `out_ready` is low, `out_hash` and `out_incr` stay unchanged. Any key presented during that time is not taken until the held result has been consumed.
- R7: When a result is taken (`out_valid` and `out_ready` both high) and no new key is accepted on the same edge, `out_valid` is low after that edge.
- R8: After synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Unit can take a key this cycle |
| in_key | input | 32 | Flow key |
| out_valid | output | 1 | Results held on the outputs |
| out_ready | input | 1 | Consumer takes the results this cycle |
| out_hash | output | 16 | First-slot hash |
| out_incr | output | 16 | Odd probe step |

## Verification
Results are checked at different points depending on the build:
- **Single-cycle build**: every result is checked on the falling edge right after the rising edge that accepted its key. Bursts, stalls and drains are lined up so that each check falls in one known cycle.
- **Serial build**: the bench waits 30 rising edges after the accepting edge and confirms `out_valid` is still low. It then confirms the value on the very next edge, which pins the 32-cycle latency from both sides.

In both builds, stalls are held for several cycles before the bench confirms that the outputs did not move and that the waiting key had not been taken.

// File: rtl/keyhash_pkg.sv
package keyhash_pkg;
  localparam int KEY_W  = 32;
  localparam int HASH_W = 16;
  localparam logic [HASH_W-1:0] SEED = 16'h1FFF;

  // One 16-round stage of the feedback register, folded into shifts.
  function automatic logic [HASH_W-1:0] fold16(input logic [HASH_W-1:0] v);
    logic [HASH_W-1:0] t;
    t = v ^ (v >> 3) ^ (v >> 6);
    t = t ^ (t >> 9);
    return t;
  endfunction

  function automatic logic [HASH_W-1:0] key_hash(input logic [KEY_W-1:0] k);
    logic [HASH_W-1:0] t;
    t = fold16(SEED ^ k[KEY_W-1:HASH_W]);
    t = t ^ HASH_W'(t << 13) ^ k[HASH_W-1:0];
    return fold16(t);
  endfunction
endpackage

// File: rtl/keyhash_incr.sv
module keyhash_incr
  import keyhash_pkg::*;
(
  input  logic [HASH_W-2:0] key_low,
  output logic [HASH_W-1:0] incr
);
  logic [HASH_W-1:0] doubled;
  assign doubled = {key_low, 1'b0};
  assign incr    = doubled - HASH_W'(1);
endmodule

// File: rtl/keyhash_comb_core.sv
module keyhash_comb_core
  import keyhash_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [HASH_W-1:0] incr_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_incr
);
  logic [HASH_W-1:0] hash_now;

  assign hash_now = key_hash(in_key);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hash  <= '0;
      out_incr  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_hash  <= hash_now;
      out_incr  <= incr_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/keyhash_serial_core.sv
module keyhash_serial_core
  import keyhash_pkg::*;
#(
  parameter int SER_BITS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [HASH_W-1:0] incr_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_incr
);
  localparam int NCYC = KEY_W / SER_BITS;
  localparam int CW   = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam int IW   = $clog2(KEY_W);
  localparam logic [HASH_W-1:0] BASE = key_hash('0);

  logic [HASH_W-1:0] col_tab [KEY_W];
  logic [KEY_W-1:0]  sh;
  logic [HASH_W-1:0] acc;
  logic [CW-1:0]     cnt;
  logic              busy;

  logic [SER_BITS-1:0] src_bits;
  logic [CW-1:0]       src_idx;
  logic [HASH_W-1:0]   nxt;
  logic                last;

  // Column i is the hash change caused by key bit i alone (hash is affine).
  always_comb begin
    for (int i = 0; i < KEY_W; i++) begin
      col_tab[i] = key_hash(KEY_W'(1) << i) ^ BASE;
    end
  end

  assign in_ready = !busy && !out_valid;
  assign src_bits = busy ? sh[SER_BITS-1:0] : in_key[SER_BITS-1:0];
  assign src_idx  = busy ? cnt : '0;
  assign last     = (src_idx == CW'(NCYC - 1));

  always_comb begin
    logic [IW-1:0] ix;
    nxt = busy ? acc : BASE;
    for (int j = 0; j < SER_BITS; j++) begin
      ix = IW'(int'(src_idx) * SER_BITS + j);
      if (src_bits[j]) nxt = nxt ^ col_tab[ix];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      sh        <= '0;
      out_hash  <= '0;
      out_incr  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_valid && in_ready) begin
        out_incr <= incr_in;
        sh       <= in_key >> SER_BITS;
        cnt      <= CW'(1);
        if (last) begin
          out_hash  <= nxt;
          out_valid <= 1'b1;
        end else begin
          acc  <= nxt;
          busy <= 1'b1;
        end
      end else if (busy) begin
        sh  <= sh >> SER_BITS;
        cnt <= cnt + CW'(1);
        if (last) begin
          out_hash  <= nxt;
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end else begin
          acc <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/keyhash_unit.sv
module keyhash_unit
  import keyhash_pkg::*;
#(
  parameter bit SERIAL_MODE = 1'b0,
  parameter int SER_BITS    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] out_hash,
  output logic [HASH_W-1:0] out_incr
);
  logic [HASH_W-1:0] incr_w;

  keyhash_incr i_incr (
    .key_low (in_key[HASH_W-2:0]),
    .incr    (incr_w)
  );

  if (SERIAL_MODE) begin : g_serial
    keyhash_serial_core #(.SER_BITS(SER_BITS)) i_core (
      .clk, .rst, .in_valid, .in_ready, .in_key,
      .incr_in (incr_w),
      .out_valid, .out_ready, .out_hash, .out_incr
    );
  end else begin : g_comb
    keyhash_comb_core i_core (
      .clk, .rst, .in_valid, .in_ready, .in_key,
      .incr_in (incr_w),
      .out_valid, .out_ready, .out_hash, .out_incr
    );
  end
endmodule

// File: rtl/keyhash_chk.sv
module keyhash_chk #(
  parameter bit SERIAL_MODE = 1'b0,
  parameter int SER_BITS    = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_hash,
  input logic [15:0] out_incr
);
  localparam int LAT = SERIAL_MODE ? (32 / SER_BITS) : 1;

  logic       pending;
  logic [7:0] cnt;
  logic       took;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (took) begin
      pending <= 1'b1;
      cnt     <= 8'd1;
    end else if (pending && out_valid) begin
      pending <= 1'b0;
    end else if (pending && cnt != 8'hFF) begin
      cnt <= cnt + 8'd1;
    end
  end

  AST_INCR_ODD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_incr[0]); // R2
  AST_LAT_DUE: assert property (@(posedge clk) disable iff (rst)
    pending && (cnt == 8'(LAT)) |-> out_valid); // R3
  AST_LAT_EARLY: assert property (@(posedge clk) disable iff (rst)
    pending && (cnt < 8'(LAT)) |-> !out_valid); // R4
  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R5
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    SERIAL_MODE && pending && !out_valid |-> !in_ready); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_hash) && $stable(out_incr)); // R6
  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !took |=> !out_valid); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R8
endmodule

bind keyhash_unit keyhash_chk #(.SERIAL_MODE(SERIAL_MODE), .SER_BITS(SER_BITS)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_hash(out_hash), .out_incr(out_incr)
);

// File: tb/test_keyhash_unit.sv
module test_keyhash_unit;
  localparam int SLAT = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        c_iv = 0, c_or = 1, c_ir, c_ov;
  logic [31:0] c_key = '0;
  logic [15:0] c_hash, c_incr;
  logic        s_iv = 0, s_or = 1, s_ir, s_ov;
  logic [31:0] s_key = '0;
  logic [15:0] s_hash, s_incr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  keyhash_unit #(.SERIAL_MODE(1'b0)) i_keyhash_unit (
    .clk, .rst, .in_valid(c_iv), .in_ready(c_ir), .in_key(c_key),
    .out_valid(c_ov), .out_ready(c_or), .out_hash(c_hash), .out_incr(c_incr));

  keyhash_unit #(.SERIAL_MODE(1'b1), .SER_BITS(1)) i_keyhash_unit_ser (
    .clk, .rst, .in_valid(s_iv), .in_ready(s_ir), .in_key(s_key),
    .out_valid(s_ov), .out_ready(s_or), .out_hash(s_hash), .out_incr(s_incr));

  // Model of R1, written step by step from the requirement.
  function automatic logic [15:0] exp_hash(input logic [31:0] k);
    logic [15:0] t, a, b;
    t = 16'h1FFF ^ k[31:16];
    a = t >> 3; b = t >> 6; t = t ^ a ^ b;
    a = t >> 9; t = t ^ a;
    a = 16'(t << 13); t = t ^ a ^ k[15:0];
    a = t >> 3; b = t >> 6; t = t ^ a ^ b;
    a = t >> 9; t = t ^ a;
    return t;
  endfunction

  function automatic logic [15:0] exp_incr(input logic [31:0] k);
    logic [31:0] w;
    w = k * 2 - 1;
    return w[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic [15:0] h, input logic [15:0] inc,
                              input logic [31:0] k);
    check({tag, " R1 hash"}, 32'(h), 32'(exp_hash(k)));
    check({tag, " R2 incr"}, 32'(inc), 32'(exp_incr(k)));
    check({tag, " R2 odd"}, 32'(inc[0]), 32'd1);
  endtask

  // Single-cycle build: one key, result due right after the accepting edge.
  task automatic c_one(input logic [31:0] k);
    @(negedge clk); c_iv = 1; c_key = k; c_or = 1;
    @(posedge clk);
    @(negedge clk); c_iv = 0;
    check("R3 valid", 32'(c_ov), 32'd1);
    check_result("R3", c_hash, c_incr, k);
    @(posedge clk);
    @(negedge clk);
    check("R7 drained", 32'(c_ov), 32'd0);
  endtask

  // Serial build: 32-cycle latency checked from both sides.
  task automatic s_one(input logic [31:0] k);
    @(negedge clk); s_iv = 1; s_key = k; s_or = 1;
    @(posedge clk);
    @(negedge clk); s_iv = 0;
    check("R5 busy not ready", 32'(s_ir), 32'd0);
    repeat (SLAT - 2) @(posedge clk);
    @(negedge clk);
    check("R4 not early", 32'(s_ov), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R4 due", 32'(s_ov), 32'd1);
    check_result("R4", s_hash, s_incr, k);
    @(posedge clk);
    @(negedge clk);
    check("R7 serial drained", 32'(s_ov), 32'd0);
    check("R5 serial ready", 32'(s_ir), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] keys [8];
    logic [31:0] ka, kb;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R8 comb valid", 32'(c_ov), 32'd0);
    check("R8 comb ready", 32'(c_ir), 32'd1);
    check("R8 serial valid", 32'(s_ov), 32'd0);
    check("R8 serial ready", 32'(s_ir), 32'd1);

    // Corner keys in both builds.
    c_one(32'h0000_0000); c_one(32'hFFFF_FFFF); c_one(32'h0001_0000);
    s_one(32'h0000_0000); s_one(32'hFFFF_FFFF); s_one(32'h0001_0000);

    for (int i = 0; i < 30; i++) c_one($urandom);
    for (int i = 0; i < 30; i++) s_one($urandom);

    // R3 back-to-back burst: one result per cycle.
    for (int i = 0; i < 8; i++) keys[i] = $urandom;
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R3 burst valid", 32'(c_ov), 32'd1);
        check_result("R3 burst", c_hash, c_incr, keys[i-1]);
        check("R5 ready while taken", 32'(c_ir), 32'd1);
      end
      if (i < 8) begin c_iv = 1; c_key = keys[i]; end
      else c_iv = 0;
    end
    @(negedge clk);
    check("R7 burst drained", 32'(c_ov), 32'd0);

    // R6 stall in the single-cycle build.
    ka = $urandom; kb = $urandom;
    @(negedge clk); c_or = 0; c_iv = 1; c_key = ka;
    @(posedge clk);
    @(negedge clk); c_key = kb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 held valid", 32'(c_ov), 32'd1);
    check("R5 stalled not ready", 32'(c_ir), 32'd0);
    check_result("R6 held", c_hash, c_incr, ka);
    c_or = 1;
    @(posedge clk);
    @(negedge clk); c_iv = 0;
    check("R6 waiting key taken", 32'(c_ov), 32'd1);
    check_result("R6 next", c_hash, c_incr, kb);
    @(posedge clk);
    @(negedge clk);
    check("R7 after stall", 32'(c_ov), 32'd0);

    // R6 stall in the serial build.
    ka = $urandom; kb = $urandom;
    @(negedge clk); s_or = 0; s_iv = 1; s_key = ka;
    @(posedge clk);
    @(negedge clk); s_key = kb;
    repeat (SLAT + 4) @(posedge clk);
    @(negedge clk);
    check("R6 serial held valid", 32'(s_ov), 32'd1);
    check("R5 serial holding not ready", 32'(s_ir), 32'd0);
    check_result("R6 serial held", s_hash, s_incr, ka);
    s_or = 1;
    @(posedge clk);
    @(negedge clk);
    check("R7 serial released", 32'(s_ov), 32'd0);
    check("R5 serial ready again", 32'(s_ir), 32'd1);
    @(posedge clk);
    @(negedge clk); s_iv = 0;
    repeat (SLAT - 1) @(posedge clk);
    @(negedge clk);
    check("R4 serial waiting key due", 32'(s_ov), 32'd1);
    check_result("R4 serial next", s_hash, s_incr, kb);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule